// File: doc/BRIEF.md
# Backup-Domain Write Sync Tracker

This block tracks register values that are written from a fast bus clock domain into a slow (about 32 kHz) always-on backup domain. Each tracked channel keeps the last bus-side write in a holding register and sets a pending flag on the next bus edge. The value then crosses into the slow domain through a toggle request/acknowledge handshake, with two-flop synchronizers in each direction. The pending flag falls only after the slow domain has taken the value on one of its clock edges. Software polls the pending bits of the sync status word until they read zero, and from then on it can rely on the backup-domain copy.

The same status word carries a reload command. A bus write with the reload bit set asks the slow domain to sample its live status. That snapshot is then copied back into a bus-side shadow register, and the reload-busy bit clears in the same cycle as the copy. A level input, the oscillator-dependency enable, gates every transfer. It is synchronized into the slow domain. While it is low, the slow side accepts no request, so the pending and busy flags stay set.

Top module: `bkup_sync_tracker`

## Requirements
- R1: After reset the sync status word reads all zeros, every slow-domain data output is zero and the shadow status is zero.
- R2: A data write to channel i makes bit i of the sync status word read 1 from the first bus clock edge after the write.
- R3: With the enable high, the written value appears on that channel's slow-domain output, and bit i returns to 0 within three slow clock periods plus four bus cycles. The slow output never changes except when the slow side accepts a request.
- R4: A write to a channel whose bit is still 1 replaces the held value, and the bit stays 1 without a break until the newest value has reached the slow domain.
- R5: While the oscillator-dependency enable is low, no transfer or reload completes, the flags stay set and the slow outputs and shadow hold. Raising the enable lets the held requests complete.
- R6: A write to the sync status word with bit 31 set starts a reload and makes bit 31 read 1 from the next bus edge. When bit 31 returns to 0, the shadow equals the backup status sampled by the slow domain. The shadow changes only in the cycle where bit 31 falls.
- R7: A write to the sync status word with bit 31 clear has no effect: no reload starts, no bit changes and the shadow holds.
- R8: Channels are independent. A write to one channel neither sets another channel's bit nor changes another channel's slow output. A write that selects several channels at once starts a transfer on each of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Fast bus clock |
| clk_slow | input | 1 | Slow backup-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside each domain |
| osc_en | input | 1 | Oscillator-dependency enable (bus domain level) |
| wr_en | input | N_CH | Per-channel data write strobe |
| wr_data | input | DATA_W | Data written to the selected channels |
| sp_wr | input | 1 | Write strobe for the sync status word |
| sp_wdata | input | 32 | Sync status write data; bit 31 requests a reload |
| sp_rdata | output | 32 | Sync status word: bits N_CH-1:0 channel pending, bit 31 reload busy |
| slow_data | output | N_CH*DATA_W | Backup-domain copy of each channel, channel 0 in the low bits |
| bkup_status | input | STAT_W | Live backup-domain status (slow domain) |
| shadow_status | output | STAT_W | Bus-side shadow of the backup status |

## Verification
A pending or busy bit is due on the first bus edge after its write, so the bench samples it at the falling edge that follows. Completion is due within about three slow periods plus four bus cycles. When the enable has just risen, two more slow periods are allowed, and after an overwrite the time is doubled. The bench therefore polls at every falling bus edge, counts the cycles against these bounds, and compares slow outputs and the shadow only after the flag has cleared. The checks that something is held or has no effect watch the ports for sixty bus cycles, which spans several slow periods.

// File: rtl/bkup_sync_pkg.sv
package bkup_sync_pkg;
  localparam int SP_W          = 32;
  localparam int SP_RELOAD_BIT = 31;
endpackage

// File: rtl/bst_sync2.sv
module bst_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/bst_rst_sync.sv
module bst_rst_sync (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic r1_q;
  logic r2_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      r1_q <= 1'b0;
      r2_q <= 1'b0;
    end else begin
      r1_q <= 1'b1;
      r2_q <= r1_q;
    end
  end

  assign rst_out_n = r2_q;
endmodule

// File: rtl/bst_xfer_chan.sv
module bst_xfer_chan #(
  parameter int DATA_W = 32
) (
  input  logic              clk_bus,
  input  logic              rst_bus_n,
  input  logic              clk_slow,
  input  logic              rst_slow_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pend,
  input  logic              en_slow,
  output logic [DATA_W-1:0] slow_q
);
  // bus side
  logic              req_q, req_d;
  logic              redo_q, redo_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              ack_b2, ack_b3_q;
  logic              arrive;
  // slow side
  logic              req_s;
  logic              ack_s_q, ack_s_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              take;

  bst_sync2 #(.W(1)) u_ack_sync (
    .clk(clk_bus), .rst_n(rst_bus_n), .d(ack_s_q), .q(ack_b2)
  );

  assign pend   = req_q ^ ack_b3_q;
  assign arrive = pend && (ack_b2 == req_q);

  always_comb begin
    hold_d = hold_q;
    req_d  = req_q;
    redo_d = redo_q;
    if (wr_en) hold_d = wr_data;
    if (arrive && (redo_q || wr_en)) begin
      req_d  = ~req_q;
      redo_d = 1'b0;
    end else if (wr_en) begin
      if (pend) redo_d = 1'b1;
      else      req_d  = ~req_q;
    end
  end

  always_ff @(posedge clk_bus or negedge rst_bus_n) begin
    if (!rst_bus_n) begin
      hold_q   <= '0;
      req_q    <= 1'b0;
      redo_q   <= 1'b0;
      ack_b3_q <= 1'b0;
    end else begin
      hold_q   <= hold_d;
      req_q    <= req_d;
      redo_q   <= redo_d;
      ack_b3_q <= ack_b2;
    end
  end

  bst_sync2 #(.W(1)) u_req_sync (
    .clk(clk_slow), .rst_n(rst_slow_n), .d(req_q), .q(req_s)
  );

  assign take = en_slow && (req_s != ack_s_q);

  always_comb begin
    ack_s_d = ack_s_q;
    dout_d  = dout_q;
    if (take) begin
      ack_s_d = req_s;
      dout_d  = hold_q;
    end
  end

  always_ff @(posedge clk_slow or negedge rst_slow_n) begin
    if (!rst_slow_n) begin
      ack_s_q <= 1'b0;
      dout_q  <= '0;
    end else begin
      ack_s_q <= ack_s_d;
      dout_q  <= dout_d;
    end
  end

  assign slow_q = dout_q;

  // R2: pending shows up the edge after a fresh write
  a_r2_pend_after_write: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    (wr_en && !pend) |=> pend);
  // R4: an overwrite never lets the flag drop
  a_r4_pend_kept: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    (wr_en && pend) |=> pend);
  a_r4_redo_holds_pend: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    redo_q |=> pend);
  // R3: slow output moves only with an acknowledge
  a_r3_dout_with_ack: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    !$stable(dout_q) |-> !$stable(ack_s_q));
  // R5: disabled slow side accepts nothing
  a_r5_hold_when_off: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    !en_slow |=> ($stable(ack_s_q) && $stable(dout_q)));
endmodule

// File: rtl/bst_reload_ctl.sv
module bst_reload_ctl #(
  parameter int STAT_W = 16
) (
  input  logic              clk_bus,
  input  logic              rst_bus_n,
  input  logic              clk_slow,
  input  logic              rst_slow_n,
  input  logic              go,
  output logic              busy,
  input  logic              en_slow,
  input  logic [STAT_W-1:0] bkup_status,
  output logic [STAT_W-1:0] shadow
);
  logic              req_q, req_d;
  logic              ack_b2, ack_b3_q;
  logic [STAT_W-1:0] shadow_q, shadow_d;
  logic              req_s;
  logic              ack_s_q, ack_s_d;
  logic [STAT_W-1:0] snap_q, snap_d;
  logic              take;

  bst_sync2 #(.W(1)) u_ack_sync (
    .clk(clk_bus), .rst_n(rst_bus_n), .d(ack_s_q), .q(ack_b2)
  );

  assign busy = req_q ^ ack_b3_q;

  always_comb begin
    req_d    = req_q;
    shadow_d = shadow_q;
    if (go && !busy) req_d = ~req_q;
    if (ack_b2 != ack_b3_q) shadow_d = snap_q;
  end

  always_ff @(posedge clk_bus or negedge rst_bus_n) begin
    if (!rst_bus_n) begin
      req_q    <= 1'b0;
      ack_b3_q <= 1'b0;
      shadow_q <= '0;
    end else begin
      req_q    <= req_d;
      ack_b3_q <= ack_b2;
      shadow_q <= shadow_d;
    end
  end

  bst_sync2 #(.W(1)) u_req_sync (
    .clk(clk_slow), .rst_n(rst_slow_n), .d(req_q), .q(req_s)
  );

  assign take = en_slow && (req_s != ack_s_q);

  always_comb begin
    ack_s_d = ack_s_q;
    snap_d  = snap_q;
    if (take) begin
      ack_s_d = req_s;
      snap_d  = bkup_status;
    end
  end

  always_ff @(posedge clk_slow or negedge rst_slow_n) begin
    if (!rst_slow_n) begin
      ack_s_q <= 1'b0;
      snap_q  <= '0;
    end else begin
      ack_s_q <= ack_s_d;
      snap_q  <= snap_d;
    end
  end

  assign shadow = shadow_q;

  // R6: reload busy rises the edge after an accepted command
  a_r6_busy_after_go: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    (go && !busy) |=> busy);
  // R6: shadow updates only together with busy falling
  a_r6_shadow_at_done: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    !$stable(shadow_q) |-> $fell(busy));
  // R5: no snapshot while disabled
  a_r5_no_snap_when_off: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    !en_slow |=> $stable(ack_s_q));
endmodule

// File: rtl/bkup_sync_tracker.sv
module bkup_sync_tracker
  import bkup_sync_pkg::*;
#(
  parameter int N_CH   = 2,
  parameter int DATA_W = 32,
  parameter int STAT_W = 16
) (
  input  logic                     clk_bus,
  input  logic                     clk_slow,
  input  logic                     rst_n,
  input  logic                     osc_en,
  input  logic [N_CH-1:0]          wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     sp_wr,
  input  logic [SP_W-1:0]          sp_wdata,
  output logic [SP_W-1:0]          sp_rdata,
  output logic [N_CH*DATA_W-1:0]   slow_data,
  input  logic [STAT_W-1:0]        bkup_status,
  output logic [STAT_W-1:0]        shadow_status
);
  localparam int PAD_W = SP_RELOAD_BIT - N_CH;

  logic            rst_bus_n;
  logic            rst_slow_n;
  logic            en_slow;
  logic [N_CH-1:0] pend;
  logic            rl_go;
  logic            rl_busy;
  logic            unused_sp_bits;

  assign unused_sp_bits = ^sp_wdata[SP_RELOAD_BIT-1:0];

  bst_rst_sync u_rst_bus  (.clk(clk_bus),  .rst_in_n(rst_n), .rst_out_n(rst_bus_n));
  bst_rst_sync u_rst_slow (.clk(clk_slow), .rst_in_n(rst_n), .rst_out_n(rst_slow_n));

  bst_sync2 #(.W(1)) u_en_sync (
    .clk(clk_slow), .rst_n(rst_slow_n), .d(osc_en), .q(en_slow)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    bst_xfer_chan #(.DATA_W(DATA_W)) u_chan (
      .clk_bus    (clk_bus),
      .rst_bus_n  (rst_bus_n),
      .clk_slow   (clk_slow),
      .rst_slow_n (rst_slow_n),
      .wr_en      (wr_en[g]),
      .wr_data    (wr_data),
      .pend       (pend[g]),
      .en_slow    (en_slow),
      .slow_q     (slow_data[g*DATA_W +: DATA_W])
    );
  end

  assign rl_go = sp_wr && sp_wdata[SP_RELOAD_BIT];

  bst_reload_ctl #(.STAT_W(STAT_W)) u_reload (
    .clk_bus     (clk_bus),
    .rst_bus_n   (rst_bus_n),
    .clk_slow    (clk_slow),
    .rst_slow_n  (rst_slow_n),
    .go          (rl_go),
    .busy        (rl_busy),
    .en_slow     (en_slow),
    .bkup_status (bkup_status),
    .shadow      (shadow_status)
  );

  assign sp_rdata = {rl_busy, {PAD_W{1'b0}}, pend};

  // R7: a status write without the reload bit cannot start a reload
  a_r7_no_reload_without_bit: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
    (sp_wr && !sp_wdata[SP_RELOAD_BIT] && !sp_rdata[SP_RELOAD_BIT]) |=> !sp_rdata[SP_RELOAD_BIT]);
endmodule

// File: tb/bkup_sync_tracker_tb.sv
module bkup_sync_tracker_tb;
  localparam int BUS_PERIOD = 10;
  localparam int SLOW_HALF  = 37;
  localparam int N_CH       = 2;
  localparam int DATA_W     = 32;
  localparam int STAT_W     = 16;
  localparam int LIM_PLAIN  = 40;
  localparam int LIM_EN     = 60;
  localparam int LIM_OVR    = 100;
  localparam int WD_LIMIT   = 150000;

  logic                   clk_bus;
  logic                   clk_slow;
  logic                   rst_n;
  logic                   osc_en;
  logic [N_CH-1:0]        wr_en;
  logic [DATA_W-1:0]      wr_data;
  logic                   sp_wr;
  logic [31:0]            sp_wdata;
  logic [31:0]            sp_rdata;
  logic [N_CH*DATA_W-1:0] slow_data;
  logic [STAT_W-1:0]      bkup_status;
  logic [STAT_W-1:0]      shadow_status;

  int checks;
  int errors;
  int cyc;
  logic [DATA_W-1:0] model [N_CH];

  bkup_sync_tracker #(.N_CH(N_CH), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_dut (
    .clk_bus(clk_bus), .clk_slow(clk_slow), .rst_n(rst_n), .osc_en(osc_en),
    .wr_en(wr_en), .wr_data(wr_data), .sp_wr(sp_wr), .sp_wdata(sp_wdata),
    .sp_rdata(sp_rdata), .slow_data(slow_data), .bkup_status(bkup_status),
    .shadow_status(shadow_status)
  );

  initial clk_bus = 1'b0;
  always #(BUS_PERIOD/2) clk_bus = ~clk_bus;
  initial clk_slow = 1'b0;
  always #(SLOW_HALF) clk_slow = ~clk_slow;

  function automatic logic [31:0] exp_rd(input logic [N_CH-1:0] pm, input logic rb);
    logic [31:0] r;
    r = '0;
    r[N_CH-1:0] = pm;
    r[31] = rb;
    return r;
  endfunction

  function automatic logic [N_CH-1:0] ch_mask(input int ch);
    logic [N_CH-1:0] m;
    m = '0;
    m[ch] = 1'b1;
    return m;
  endfunction

  task automatic chk_eq(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_ch(input int ch, input logic [DATA_W-1:0] d);
    @(negedge clk_bus);
    wr_en = ch_mask(ch);
    wr_data = d;
    @(negedge clk_bus);
    wr_en = '0;
  endtask

  task automatic write_sp(input logic [31:0] d);
    @(negedge clk_bus);
    sp_wr = 1'b1;
    sp_wdata = d;
    @(negedge clk_bus);
    sp_wr = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (sp_rdata != 32'h0 && n < 400) begin
      @(negedge clk_bus);
      n++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_bus);
  endtask

  always @(posedge clk_bus) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog R3: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [STAT_W-1:0] st_old;
    logic [STAT_W-1:0] st_new;
    checks = 0;
    errors = 0;
    cyc = 0;
    rst_n = 1'b0;
    osc_en = 1'b0;
    wr_en = '0;
    wr_data = '0;
    sp_wr = 1'b0;
    sp_wdata = '0;
    bkup_status = '0;
    for (int i = 0; i < N_CH; i++) model[i] = '0;
    void'($urandom(32'd5147));
    idle(3);
    rst_n = 1'b1;
    idle(30);

    // R1 reset state
    chk_eq("R1", "status word", sp_rdata, 32'h0);
    chk_eq("R1", "slow data", slow_data, '0);
    chk_eq("R1", "shadow", shadow_status, '0);

    // R5 enable low holds a transfer
    write_ch(0, 32'hA5A5_0001);
    chk_eq("R2", "pending after write", sp_rdata, exp_rd(2'b01, 1'b0));
    idle(60);
    chk_eq("R5", "pending held while off", sp_rdata, exp_rd(2'b01, 1'b0));
    chk_eq("R5", "slow data held while off", slow_data[0 +: DATA_W], 32'h0);
    osc_en = 1'b1;
    wait_idle(n);
    chk_eq("R5", "completes after enable", n <= LIM_EN, 1);
    model[0] = 32'hA5A5_0001;
    chk_eq("R3", "ch0 value", slow_data[0 +: DATA_W], model[0]);

    // random transfers with occasional overwrite
    for (int it = 0; it < 40; it++) begin
      int ch;
      int gap;
      bit ow;
      logic [DATA_W-1:0] d;
      ch  = int'($urandom % N_CH);
      d   = $urandom;
      ow  = (($urandom % 3) == 0);
      gap = int'($urandom % 10);
      write_ch(ch, d);
      model[ch] = d;
      chk_eq("R2", "pending after write", sp_rdata, exp_rd(ch_mask(ch), 1'b0));
      if (ow) begin
        idle(gap);
        chk_eq("R4", "pending before overwrite", sp_rdata[ch], 1'b1);
        d = $urandom;
        write_ch(ch, d);
        model[ch] = d;
        chk_eq("R4", "pending after overwrite", sp_rdata, exp_rd(ch_mask(ch), 1'b0));
      end
      wait_idle(n);
      chk_eq("R3", "completion bound", n <= (ow ? LIM_OVR : LIM_PLAIN), 1);
      for (int c = 0; c < N_CH; c++)
        chk_eq(c == ch ? "R3" : "R8", "slow value", slow_data[c*DATA_W +: DATA_W], model[c]);
    end

    // R4 back-to-back overwrite
    write_ch(1, 32'h1111_2222);
    write_ch(1, 32'h3333_4444);
    model[1] = 32'h3333_4444;
    chk_eq("R4", "pending back-to-back", sp_rdata, exp_rd(2'b10, 1'b0));
    wait_idle(n);
    chk_eq("R4", "last value wins", slow_data[DATA_W +: DATA_W], model[1]);

    // R4 late overwrite near capture
    write_ch(0, 32'h0BAD_F00D);
    idle(15);
    write_ch(0, 32'h600D_CAFE);
    model[0] = 32'h600D_CAFE;
    chk_eq("R4", "pending late overwrite", sp_rdata[0], 1'b1);
    wait_idle(n);
    chk_eq("R4", "late overwrite value", slow_data[0 +: DATA_W], model[0]);

    // R8 both channels at once
    @(negedge clk_bus);
    wr_en = '1;
    wr_data = 32'hC0DE_0042;
    @(negedge clk_bus);
    wr_en = '0;
    chk_eq("R8", "both pending", sp_rdata, exp_rd('1, 1'b0));
    wait_idle(n);
    for (int c = 0; c < N_CH; c++) begin
      model[c] = 32'hC0DE_0042;
      chk_eq("R8", "both values", slow_data[c*DATA_W +: DATA_W], model[c]);
    end

    // R6 reloads
    for (int it = 0; it < 4; it++) begin
      st_new = STAT_W'($urandom);
      bkup_status = st_new;
      idle(20);
      write_sp(32'h8000_0000);
      chk_eq("R6", "reload busy", sp_rdata, exp_rd('0, 1'b1));
      wait_idle(n);
      chk_eq("R6", "reload bound", n <= LIM_PLAIN, 1);
      chk_eq("R6", "shadow value", shadow_status, st_new);
    end

    // R7 write without reload bit
    st_old = shadow_status;
    bkup_status = ~st_old;
    idle(20);
    write_sp(32'h7FFF_FFFF);
    chk_eq("R7", "no busy", sp_rdata, 32'h0);
    idle(60);
    chk_eq("R7", "still idle", sp_rdata, 32'h0);
    chk_eq("R7", "shadow held", shadow_status, st_old);

    // R5 reload held while off
    osc_en = 1'b0;
    idle(30);
    st_new = st_old ^ 16'h5A5A;
    bkup_status = st_new;
    write_sp(32'hFFFF_FFFF);
    idle(60);
    chk_eq("R5", "reload held while off", sp_rdata, exp_rd('0, 1'b1));
    chk_eq("R5", "shadow held while off", shadow_status, st_old);
    osc_en = 1'b1;
    wait_idle(n);
    chk_eq("R5", "reload after enable", n <= LIM_EN, 1);
    chk_eq("R6", "shadow after enable", shadow_status, st_new);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule